// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block turns word-wide host requests into correctly timed bus cycles on one asynchronous external memory region, such as a NAND flash. A host raises a request with a direction, a byte address and write data. The block answers with a one-cycle acknowledge, and for reads it returns the assembled word with that acknowledge. On the pin side it drives a pair of active-low chip selects, the output-enable and write-enable strobes, the bus address, the write data with its drive enable, and the command-latch and address-latch lines.

Each bus cycle has three phases: address/data setup, the strobe itself, and hold. A 32-bit timing word sets the length of each phase, separately for reads and writes. The same word sets a turnaround gap that follows read cycles, the data bus width, and a mode that narrows the chip select to the strobe window. One host word becomes four byte cycles or two halfword cycles. The command-latch and address-latch lines come from fixed bits of the host byte address. An address mask decides which of the two chip selects is used.

The block also passes the shared, wired-AND ready/busy line of the attached devices back to the host through one register.

Top module: `amem_seq`

## Requirements
- R1: While reset is asserted, both chip selects, the output-enable and the write-enable are high, and the acknowledge and the data drive enable are low.
- R2: Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4]. Each phase lasts its field value plus one clock. Setup is counted from chip select falling to strobe falling. The strobe stays low for the strobe phase only. Hold is counted from strobe rising to chip select rising.
- R3: Turnaround is field [3:2]. Between consecutive bus cycles of a read word, the chip selects stay high for exactly turnaround+1 clocks. A request accepted right after a read also waits turnaround+1 clocks first. Bus cycles of a write word follow one another with the chip select held low, so the strobe-to-strobe gap is write hold + write setup + 2 clocks.
- R4: Width field [1:0] equal to 0 gives an 8-bit bus. Such a word becomes four byte cycles at base, base+1, base+2 and base+3, with write byte k on data bits [7:0] and the upper bits zero. Any other width value gives two halfword cycles at base and base+2, with the low half first. The base is the host address with bits [1:0] cleared. The bus address stays steady while a strobe is low.
- R5: Read data is taken on the last strobe clock of each bus cycle and packed little-endian: byte k, or halfword k, of the returned word comes from bus cycle k. The word is presented together with the acknowledge.
- R6: The command-latch line equals host address bit 4 and the address-latch line equals host address bit 3. Both hold that value throughout each bus cycle.
- R7: When the host address ANDed with the secondary-select mask is nonzero, chip select bit 1 is used; otherwise bit 0 is used. At most one chip select is ever low, and a strobe is never low without a chip select low.
- R8: With timing word bit 31 set, the chip select is low only during the strobe phase.
- R9: Timing word bit 30 (extended wait) has no effect on any timing.
- R10: The timing word is captured when a request is accepted. A change on the configuration input during an access does not alter that access.
- R11: The ready output equals the ready/busy input delayed by one clock.
- R12: The acknowledge is a single-clock pulse. A request still high during that pulse is not accepted again.
- R13: Output-enable and write-enable are never low together. Output-enable goes low only for reads and write-enable only for writes. The data drive enable is high only during the bus cycles of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Timing and mode word |
| req_i | input | 1 | Host request, held until acknowledge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Host byte address |
| req_wdata_i | input | 32 | Host write word |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Assembled read word |
| mem_cs_n_o | output | 2 | Active-low chip selects (bit 1 = secondary) |
| mem_oe_n_o | output | 1 | Active-low output-enable strobe |
| mem_we_n_o | output | 1 | Active-low write-enable strobe |
| mem_addr_o | output | AW | Bus byte address of the current bus cycle |
| mem_dout_o | output | 16 | Write data lanes |
| mem_dout_en_o | output | 1 | Write data drive enable |
| mem_din_i | input | 16 | Read data lanes |
| nand_cle_o | output | 1 | Command-latch line |
| nand_ale_o | output | 1 | Address-latch line |
| rdy_i | input | 1 | Wired-AND ready/busy of the devices |
| rdy_o | output | 1 | Registered ready status |

## Verification
The assertions assume that the host keeps its request high until it sees the acknowledge, and that the ready/busy input changes only between clock edges. The stimulus meets both conditions: every request is driven on a falling edge and held until the acknowledge is observed, and the request is dropped on that same falling edge. The bus address property also assumes that the memory side never changes the address while a strobe is low, which the block guarantees by holding its beat state. The bench memory answers combinationally from the bus address, so read data is always settled before the last strobe clock.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int CNT_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // Layout of the timing word, most significant field first.
    typedef struct packed {
        logic       narrow_cs;
        logic       ext_wait;
        logic [3:0] wr_setup;
        logic [5:0] wr_strobe;
        logic [2:0] wr_hold;
        logic [3:0] rd_setup;
        logic [5:0] rd_strobe;
        logic [2:0] rd_hold;
        logic [1:0] turn;
        logic [1:0] width;
    } timing_t;

endpackage

// File: rtl/amem_cfg_unpack.sv
module amem_cfg_unpack
    import amem_pkg::*;
(
    input  logic [31:0]      word_i,
    input  logic             is_wr_i,
    output logic [CNT_W-1:0] setup_o,
    output logic [CNT_W-1:0] strobe_o,
    output logic [CNT_W-1:0] hold_o,
    output logic [CNT_W-1:0] turn_o,
    output logic             wide_o,
    output logic             narrow_cs_o
);
    timing_t t;
    assign t = timing_t'(word_i);

    always_comb begin
        if (is_wr_i) begin
            setup_o  = CNT_W'(t.wr_setup);
            strobe_o = CNT_W'(t.wr_strobe);
            hold_o   = CNT_W'(t.wr_hold);
        end else begin
            setup_o  = CNT_W'(t.rd_setup);
            strobe_o = CNT_W'(t.rd_strobe);
            hold_o   = CNT_W'(t.rd_hold);
        end
        turn_o      = CNT_W'(t.turn);
        wide_o      = (t.width != 2'd0);
        narrow_cs_o = t.narrow_cs;
    end
endmodule

// File: rtl/amem_lane.sv
module amem_lane #(
    parameter int AW = 16
) (
    input  logic [AW-1:2] base_i,
    input  logic [1:0]    beat_i,
    input  logic          wide_i,
    input  logic [31:0]   wdata_i,
    output logic [AW-1:0] addr_o,
    output logic [15:0]   data_o
);
    always_comb begin
        if (wide_i) begin
            addr_o = {base_i, beat_i[0], 1'b0};
            data_o = beat_i[0] ? wdata_i[31:16] : wdata_i[15:0];
        end else begin
            addr_o = {base_i, beat_i};
            data_o = {8'h00, wdata_i[8*beat_i +: 8]};
        end
    end
endmodule

// File: rtl/amem_rdy_sync.sv
module amem_rdy_sync (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic q_q;
    always_ff @(posedge clk_i) q_q <= d_i;
    assign q_o = q_q;
endmodule

// File: rtl/amem_seq.sv
module amem_seq
    import amem_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] CS2_MASK = AW'(16'h4000),
    parameter int          ALE_BIT  = 3,
    parameter int          CLE_BIT  = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [31:0]   cfg_i,
    input  logic          req_i,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [31:0]   req_wdata_i,
    output logic          ack_o,
    output logic [31:0]   rdata_o,
    output logic [1:0]    mem_cs_n_o,
    output logic          mem_oe_n_o,
    output logic          mem_we_n_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [15:0]   mem_dout_o,
    output logic          mem_dout_en_o,
    input  logic [15:0]   mem_din_i,
    output logic          nand_cle_o,
    output logic          nand_ale_o,
    input  logic          rdy_i,
    output logic          rdy_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       beat;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [31:0]      wdata;
        logic [31:0]      rdata;
        logic [31:0]      cfg;
        logic             last_rd;
        logic             ack;
    } seq_t;

    seq_t q, d;

    logic             idle;
    logic [31:0]      dec_word;
    logic             dec_wr;
    logic [CNT_W-1:0] t_setup, t_strobe, t_hold, t_turn;
    logic             wide, narrow_cs;
    logic             last_beat;

    assign idle     = (q.ph == PH_IDLE);
    assign dec_word = idle ? cfg_i    : q.cfg;
    assign dec_wr   = idle ? req_we_i : q.wr;

    amem_cfg_unpack u_unpack (
        .word_i      (dec_word),
        .is_wr_i     (dec_wr),
        .setup_o     (t_setup),
        .strobe_o    (t_strobe),
        .hold_o      (t_hold),
        .turn_o      (t_turn),
        .wide_o      (wide),
        .narrow_cs_o (narrow_cs)
    );

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        last_beat = wide ? q.beat[0] : (q.beat == 2'd3);
        unique case (q.ph)
            PH_IDLE: begin
                if (req_i && !q.ack) begin
                    d.wr    = req_we_i;
                    d.addr  = req_addr_i;
                    d.wdata = req_wdata_i;
                    d.cfg   = cfg_i;
                    d.beat  = 2'd0;
                    d.rdata = '0;
                    if (q.last_rd) begin
                        d.ph  = PH_TURN;
                        d.cnt = t_turn;
                    end else begin
                        d.ph  = PH_SETUP;
                        d.cnt = t_setup;
                    end
                end
            end
            PH_TURN: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_SETUP;
                    d.cnt = t_setup;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_STROBE;
                    d.cnt = t_strobe;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    if (!q.wr) begin
                        if (wide) d.rdata[16*q.beat[0] +: 16] = mem_din_i;
                        else      d.rdata[8*q.beat +: 8]      = mem_din_i[7:0];
                    end
                    d.ph  = PH_HOLD;
                    d.cnt = t_hold;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    if (last_beat) begin
                        d.ph      = PH_IDLE;
                        d.ack     = 1'b1;
                        d.last_rd = !q.wr;
                    end else begin
                        d.beat = q.beat + 2'd1;
                        if (!q.wr) begin
                            d.ph  = PH_TURN;
                            d.cnt = t_turn;
                        end else begin
                            d.ph  = PH_SETUP;
                            d.cnt = t_setup;
                        end
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    logic active, strobing, cs_on, use_cs2;

    assign active   = (q.ph == PH_SETUP) || (q.ph == PH_STROBE) || (q.ph == PH_HOLD);
    assign strobing = (q.ph == PH_STROBE);
    assign cs_on    = narrow_cs ? strobing : active;
    assign use_cs2  = |(q.addr & CS2_MASK);

    amem_lane #(.AW(AW)) u_lane (
        .base_i  (q.addr[AW-1:2]),
        .beat_i  (q.beat),
        .wide_i  (wide),
        .wdata_i (q.wdata),
        .addr_o  (mem_addr_o),
        .data_o  (mem_dout_o)
    );

    amem_rdy_sync u_rdy (
        .clk_i (clk_i),
        .d_i   (rdy_i),
        .q_o   (rdy_o)
    );

    assign mem_cs_n_o    = {~(cs_on & use_cs2), ~(cs_on & ~use_cs2)};
    assign mem_oe_n_o    = ~(strobing & ~q.wr);
    assign mem_we_n_o    = ~(strobing & q.wr);
    assign mem_dout_en_o = active & q.wr;
    assign nand_cle_o    = active & q.addr[CLE_BIT];
    assign nand_ale_o    = active & q.addr[ALE_BIT];
    assign ack_o         = q.ack;
    assign rdata_o       = q.rdata;
endmodule

// File: rtl/amem_seq_chk.sv
module amem_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [1:0]    mem_cs_n_o,
    input logic          mem_oe_n_o,
    input logic          mem_we_n_o,
    input logic          mem_dout_en_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          ack_o,
    input logic          rdy_i,
    input logic          rdy_o
);
    p_strobe_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!mem_oe_n_o && !mem_we_n_o));

    p_dout_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_dout_en_o |-> mem_oe_n_o);

    p_cs_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~mem_cs_n_o));

    p_stb_in_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_oe_n_o || !mem_we_n_o) |-> (mem_cs_n_o != 2'b11));

    p_ack_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    p_rdy_delay_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rdy_o == $past(rdy_i)));

    p_addr_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!mem_oe_n_o || !mem_we_n_o) && $past(!mem_oe_n_o || !mem_we_n_o))
            |-> $stable(mem_addr_o));
endmodule

bind amem_seq amem_seq_chk #(.AW(AW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mem_cs_n_o    (mem_cs_n_o),
    .mem_oe_n_o    (mem_oe_n_o),
    .mem_we_n_o    (mem_we_n_o),
    .mem_dout_en_o (mem_dout_en_o),
    .mem_addr_o    (mem_addr_o),
    .ack_o         (ack_o),
    .rdy_i         (rdy_i),
    .rdy_o         (rdy_o)
);

// File: tb/amem_seq_tb_top.sv
module amem_seq_tb_top;
    localparam int AW = 16;
    localparam logic [AW-1:0] CS2M = 16'h4000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [31:0]   cfg;
    logic          req, req_we;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          ack;
    logic [31:0]   rdata;
    logic [1:0]    cs_n;
    logic          oe_n, we_n;
    logic [AW-1:0] maddr;
    logic [15:0]   dout;
    logic          dout_en;
    logic [15:0]   din;
    logic          cle, ale;
    logic          rdy_in, rdy_out;

    amem_seq #(.AW(AW), .CS2_MASK(CS2M)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .req_i(req), .req_we_i(req_we),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack), .rdata_o(rdata),
        .mem_cs_n_o(cs_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_addr_o(maddr),
        .mem_dout_o(dout), .mem_dout_en_o(dout_en), .mem_din_i(din),
        .nand_cle_o(cle), .nand_ale_o(ale), .rdy_i(rdy_in), .rdy_o(rdy_out)
    );

    function automatic logic [15:0] mem_fn(logic [AW-1:0] a);
        return {a[7:0] ^ 8'h3C, a[7:0] + 8'h51};
    endfunction
    always_comb din = mem_fn(maddr);

    typedef struct {
        bit            wr;
        bit            sel;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        int            lag, width, hold, gap, turn;
        bit            cle, ale, cs2;
        string         tg;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(bit sel, bit xw, int wsu, int wst, int wh,
                                           int rsu, int rst, int rh, int ta, int sz);
        return {sel, xw, 4'(wsu), 6'(wst), 3'(wh), 4'(rsu), 6'(rst), 3'(rh), 2'(ta), 2'(sz)};
    endfunction

    // Monitor: measures pin timing at falling edges and compares with the queue.
    int   cyc = 0;
    int   t_cs = 0, t_csr = 0, t_sf = 0, t_sr = 0;
    bit   fresh = 0, stb_p = 0, cs_p = 0;
    exp_t last_e;

    always @(negedge clk) begin
        bit   stb, csa;
        exp_t e;
        stb = !oe_n || !we_n;
        csa = (cs_n != 2'b11);
        cyc++;
        if (rst_n) begin
            if (csa && !cs_p) begin
                t_cs  = cyc;
                fresh = 1;
                if (sbq.size() > 0 && sbq[0].turn > 0)
                    chk({"R3", sbq[0].tg}, cyc - t_csr, sbq[0].turn, "turnaround");
            end
            if (stb && !stb_p) begin
                t_sf = cyc;
                if (sbq.size() == 0) begin
                    chk("R13", 1, 0, "unexpected strobe");
                end else begin
                    e = sbq[0];
                    if (fresh) chk({e.sel ? "R8" : "R2", e.tg}, cyc - t_cs, e.lag, "setup");
                    fresh = 0;
                    if (e.gap > 0) chk({"R3", e.tg}, cyc - t_sr, e.gap, "write gap");
                    chk({"R4", e.tg}, maddr, e.addr, "bus address");
                    chk({"R6", e.tg}, {cle, ale}, {e.cle, e.ale}, "cle/ale");
                    chk({"R7", e.tg}, cs_n, e.cs2 ? 2'b01 : 2'b10, "chip select");
                    chk({"R13", e.tg}, {oe_n, we_n}, e.wr ? 2'b10 : 2'b01, "strobe kind");
                    chk({"R13", e.tg}, dout_en, e.wr, "drive enable");
                    if (e.wr) chk({"R4", e.tg}, dout, e.data, "write lane");
                end
            end
            if (!stb && stb_p && sbq.size() > 0) begin
                last_e = sbq.pop_front();
                chk({"R2", last_e.tg}, cyc - t_sf, last_e.width, "strobe width");
                t_sr = cyc;
            end
            if (!csa && cs_p) begin
                t_csr = cyc;
                chk({last_e.sel ? "R8" : "R2", last_e.tg}, cyc - t_sr, last_e.hold, "hold");
            end
        end
        stb_p = stb;
        cs_p  = csa;
    end

    // Driver: pushes the expected bus cycles, then runs the handshake.
    task automatic access(bit wr, logic [AW-1:0] a, logic [31:0] wd, logic [31:0] c,
                          bit swap, logic [31:0] c2, string tg);
        bit          sel, wide;
        int          su, st, hd, ta, n;
        logic [31:0] exp_rd;
        logic [15:0] m;
        sel  = c[31];
        wide = (c[1:0] != 2'd0);
        su   = wr ? int'(c[29:26]) : int'(c[16:13]);
        st   = wr ? int'(c[25:20]) : int'(c[12:7]);
        hd   = wr ? int'(c[19:17]) : int'(c[6:4]);
        ta   = int'(c[3:2]);
        n    = wide ? 2 : 4;
        exp_rd = '0;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.wr    = wr;
            e.sel   = sel;
            e.addr  = wide ? {a[AW-1:2], k[0], 1'b0} : {a[AW-1:2], k[1:0]};
            e.data  = wide ? (k == 0 ? wd[15:0] : wd[31:16]) : {8'h00, wd[8*k +: 8]};
            e.lag   = sel ? 0 : su + 1;
            e.width = st + 1;
            e.hold  = sel ? 0 : hd + 1;
            e.gap   = (wr && k > 0) ? hd + su + 2 : 0;
            e.turn  = (!wr && k > 0 && !sel) ? ta + 1 : 0;
            e.cle   = a[4];
            e.ale   = a[3];
            e.cs2   = |(a & CS2M);
            e.tg    = tg;
            m = mem_fn(e.addr);
            if (wide) exp_rd[16*k +: 16] = m;
            else      exp_rd[8*k +: 8]   = m[7:0];
            sbq.push_back(e);
        end
        cfg       = c;
        req_we    = wr;
        req_addr  = a;
        req_wdata = wd;
        req       = 1'b1;
        if (swap) begin
            repeat (3) @(negedge clk);
            cfg = c2;
        end
        forever begin
            @(negedge clk);
            if (ack) break;
        end
        req = 1'b0;
        if (!wr) chk({"R5", tg}, rdata, exp_rd, "read word");
        @(negedge clk);
        chk("R12", ack, 1'b0, "acknowledge width");
    endtask

    initial begin
        int wd_cnt;
        wd_cnt = 0;
        while (!finished && wd_cnt < 150000) begin
            @(posedge clk);
            wd_cnt++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] cfg_a, cfg_b, cfg_c, cfg_z, cfg_m;
        rst_n = 1'b0; cfg = '0; req = 1'b0; req_we = 1'b0;
        req_addr = '0; req_wdata = '0; rdy_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {cs_n, oe_n, we_n, ack, dout_en}, 6'b111100, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);

        cfg_a = mk_cfg(0, 0, 1, 3, 1, 0, 3, 0, 3, 0);
        cfg_b = mk_cfg(1, 0, 2, 4, 2, 1, 2, 1, 2, 1);
        cfg_c = mk_cfg(0, 1, 0, 0, 0, 2, 5, 2, 1, 2);
        cfg_z = mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cfg_m = mk_cfg(0, 0, 15, 63, 7, 15, 63, 7, 3, 0);

        // 8-bit bus: write with the command-latch bit set, then a read at an unaligned address
        access(1, 16'h0010, 32'hA1B2C3D4, cfg_a, 0, '0, "");
        access(0, 16'h000B, '0, cfg_a, 0, '0, "");
        access(1, 16'h0003, 32'h0F1E2D3C, cfg_a, 0, '0, "");
        // 16-bit bus, secondary chip select, narrow chip select mode (R8)
        access(1, 16'h4018, 32'h55AA1234, cfg_b, 0, '0, "(R8)");
        access(0, 16'h4006, '0, cfg_b, 0, '0, "(R8)");
        // extended wait bit set must not alter timing (R9)
        access(0, 16'h1234, '0, cfg_c, 0, '0, "(R9)");
        access(1, 16'h0100, 32'hDEADBEEF, cfg_c, 0, '0, "(R9)");
        // minimal phases
        access(0, 16'h0020, '0, cfg_z, 0, '0, "");
        access(1, 16'h0024, 32'h89ABCDEF, cfg_z, 0, '0, "");
        // configuration changed mid-access is not applied (R10)
        access(0, 16'h0050, '0, cfg_m, 1, cfg_z, "(R10)");
        access(1, 16'h0058, 32'h13579BDF, cfg_m, 1, cfg_a, "(R10)");

        // ready status: one clock behind the input (R11)
        @(negedge clk);
        rdy_in = 1'b1;
        #1 chk("R11", rdy_out, 1'b0, "ready before edge");
        @(negedge clk);
        chk("R11", rdy_out, 1'b1, "ready after edge");
        rdy_in = 1'b0;
        @(negedge clk);
        chk("R11", rdy_out, 1'b0, "ready cleared");

        repeat (4) @(negedge clk);
        chk("R4", sbq.size(), 0, "bus cycles left unseen");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule